// File: doc/BRIEF.md
# Fractional Audio Clock Divider

This block derives audio clock enables from a single fast system clock. A fractional stage adds a numerator X to an accumulator on each clock and takes away a denominator Y whenever the sum reaches Y. Every such wrap toggles a master-clock level, so the master clock runs at the system rate times X/Y, halved once more by the toggle. A one-cycle master-clock enable marks each rising transition of that level.

A second stage counts enables from a selectable source and emits a bit-clock enable once every N+1 of them. The source is either this block's own master-clock enable or an enable supplied from outside, for example by the opposite audio direction. All outputs are synchronous enables and levels in the system clock domain; no derived clock is generated.

Settings with a zero numerator or denominator stop the master clock. A numerator larger than the denominator raises a configuration error and also holds the clock. Any change of X, Y, N or the source select restarts both stages from zero, so the first output after a reconfiguration has a full, well-defined phase.

Top module: `audio_clk_div`

## Requirements
- R1: Each accumulator wrap toggles `mclk_o`. `mclk_en_o` is high for exactly one cycle, in the cycle in which `mclk_o` turns high. The average rate is X/(2*Y) enables per system clock; X equal to Y gives one enable every second clock.
- R2: While X or Y is zero, `mclk_o` is held low, `mclk_en_o` stays low and `cfg_err_o` is low.
- R3: While X > Y with both nonzero, `cfg_err_o` is high, `mclk_o` is held low and no `mclk_en_o` pulse appears.
- R4: `bclk_en_o` pulses for one cycle, in the cycle after every (N+1)-th selected source enable, so its rate is the source rate divided by N+1. N = 0 passes every source enable on one cycle late.
- R5: `src_sel_i` = 2'b00 selects the internal master-clock enable as the bit-clock source. `src_sel_i` = 2'b10 selects `ext_mclk_en_i`.
- R6: `src_sel_i` = 2'b01 or 2'b11 selects no source, and `bclk_en_o` stays low.
- R7: A clock edge that samples X, Y, N or `src_sel_i` different from the previous edge clears both stages. After that edge, the first `mclk_en_o` pulse follows the ceil(Y/X)-th edge, and with N = 0 the first `bclk_en_o` pulse follows one edge later.
- R8: While `rst_ni` is low, `mclk_o`, `mclk_en_o` and `bclk_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| num_i | input | 8 | Fractional numerator X |
| den_i | input | 8 | Fractional denominator Y |
| bit_div_i | input | 8 | Bit-clock divide value N (divides by N+1) |
| src_sel_i | input | 2 | Bit-clock source: 00 internal, 10 external, others none |
| ext_mclk_en_i | input | 1 | External master-clock enable |
| mclk_o | output | 1 | Master-clock level |
| mclk_en_o | output | 1 | One-cycle pulse on each rising transition of the master clock |
| bclk_en_o | output | 1 | Bit-clock enable pulse |
| cfg_err_o | output | 1 | Numerator exceeds denominator |

## Verification
The bench counts pulses over long windows for ratios that wrap exactly and for ratios that do not, and for X equal to Y and maximal N. A wrong halving or a wrong remainder carry would shift those counts far outside the one-pulse tolerance. It checks the exact cycle of the first enables after a reconfiguration. A design that kept its accumulator phase, or let a partial count survive, would fire early there. It also checks that zero settings and X > Y give no pulses, and that reserved source codes give no bit clock even while external enables arrive. A design that decoded only one bit of the select would leak bit-clock pulses in that case.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef enum logic [1:0] {
    SRC_OWN = 2'b00,
    SRC_EXT = 2'b10
  } src_sel_e;
endpackage

// File: rtl/afd_cfg_ctl.sv
module afd_cfg_ctl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] div_i,
  input  logic [1:0]   src_i,
  output logic         clr_o,
  output logic         stop_o,
  output logic         err_o
);
  localparam int CW = 3*W + 2;

  logic [CW-1:0] cfg_d, cfg_q;
  logic          zero;

  assign cfg_d = {num_i, den_i, div_i, src_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign clr_o  = (cfg_d != cfg_q);
  assign zero   = (num_i == '0) || (den_i == '0);
  assign err_o  = !zero && (num_i > den_i);
  assign stop_o = zero || err_o;
endmodule

// File: rtl/afd_frac_acc.sv
module afd_frac_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         stop_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         mclk_o,
  output logic         mclk_en_o
);
  localparam int AW = W + 1;

  logic [W-1:0]  acc_q;
  logic          mclk_q, en_q;
  logic [AW-1:0] sum, rem;
  logic          wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + {1'b0, num_i};
    wrap = (sum >= {1'b0, den_i});
    rem  = sum - {1'b0, den_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      mclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (clr_i || stop_i) begin
      acc_q  <= '0;
      mclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= wrap && !mclk_q;
      if (wrap) begin
        acc_q  <= rem[W-1:0];
        mclk_q <= ~mclk_q;
      end else begin
        acc_q  <= sum[W-1:0];
      end
    end
  end

  assign mclk_o    = mclk_q;
  assign mclk_en_o = en_q;
endmodule

// File: rtl/afd_bclk_div.sv
module afd_bclk_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         src_en_i,
  input  logic [W-1:0] div_i,
  output logic         bclk_en_o
);
  logic [W-1:0] cnt_q;
  logic         en_q;
  logic         last;

  assign last = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= src_en_i && last;
      if (src_en_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign bclk_en_o = en_q;
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic [W-1:0] bit_div_i,
  input  logic [1:0]   src_sel_i,
  input  logic         ext_mclk_en_i,
  output logic         mclk_o,
  output logic         mclk_en_o,
  output logic         bclk_en_o,
  output logic         cfg_err_o
);
  import afd_pkg::*;

  logic clr, stop, own_en, src_en;

  afd_cfg_ctl #(.W(W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .num_i  (num_i),
    .den_i  (den_i),
    .div_i  (bit_div_i),
    .src_i  (src_sel_i),
    .clr_o  (clr),
    .stop_o (stop),
    .err_o  (cfg_err_o)
  );

  afd_frac_acc #(.W(W)) u_frac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .stop_i    (stop),
    .num_i     (num_i),
    .den_i     (den_i),
    .mclk_o    (mclk_o),
    .mclk_en_o (own_en)
  );

  always_comb begin
    case (src_sel_i)
      SRC_OWN: src_en = own_en;
      SRC_EXT: src_en = ext_mclk_en_i;
      default: src_en = 1'b0;
    endcase
  end

  afd_bclk_div #(.W(W)) u_bclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .src_en_i  (src_en),
    .div_i     (bit_div_i),
    .bclk_en_o (bclk_en_o)
  );

  assign mclk_en_o = own_en;
endmodule

// File: rtl/afd_checker.sv
module afd_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] num_i,
  input logic [W-1:0] den_i,
  input logic [W-1:0] bit_div_i,
  input logic [1:0]   src_sel_i,
  input logic         src_en,
  input logic         mclk_o,
  input logic         mclk_en_o,
  input logic         bclk_en_o,
  input logic         cfg_err_o
);
  AST_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_en_o |-> (mclk_o && !$past(mclk_o))); // R1

  AST_EN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_en_o |=> !mclk_en_o); // R1

  AST_ZERO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((num_i == '0) || (den_i == '0)) |=> (!mclk_o && !mclk_en_o)); // R2

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (!mclk_o && !mclk_en_o)); // R3

  AST_BCLK_FROM_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_en_o |-> $past(src_en)); // R4

  AST_RSVD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_i[0] |=> !bclk_en_o); // R6

  AST_CHG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(num_i) || !$stable(den_i) || !$stable(bit_div_i) || !$stable(src_sel_i))
    |=> (!mclk_o && !mclk_en_o && !bclk_en_o)); // R7

  always_comb begin
    if (!rst_ni) AST_RST_LOW: assert (!mclk_o && !mclk_en_o && !bclk_en_o); // R8
  end
endmodule

bind audio_clk_div afd_checker #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .num_i     (num_i),
  .den_i     (den_i),
  .bit_div_i (bit_div_i),
  .src_sel_i (src_sel_i),
  .src_en    (src_en),
  .mclk_o    (mclk_o),
  .mclk_en_o (mclk_en_o),
  .bclk_en_o (bclk_en_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/audio_clk_div_test.sv
module audio_clk_div_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 2400;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [7:0]  x;
    logic [7:0]  y;
    logic [7:0]  n;
    logic [15:0] exp_m;
    logic [15:0] exp_b;
  } vec_t;

  // expected counts over WIN cycles: WIN*X/(2Y), then /(N+1)
  localparam vec_t VEC [NVEC] = '{
    '{8'd1,   8'd2,   8'd0,   16'd600,  16'd600},
    '{8'd1,   8'd4,   8'd3,   16'd300,  16'd75},
    '{8'd3,   8'd8,   8'd1,   16'd450,  16'd225},
    '{8'd5,   8'd5,   8'd4,   16'd1200, 16'd240},
    '{8'd7,   8'd200, 8'd0,   16'd42,   16'd42},
    '{8'd255, 8'd255, 8'd255, 16'd1200, 16'd4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] num = '0, den = '0, bdiv = '0;
  logic [1:0] sel = 2'b00;
  logic       ext_en = 1'b0;
  logic       mclk, mclk_en, bclk_en, cfg_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clk_div uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .num_i         (num),
    .den_i         (den),
    .bit_div_i     (bdiv),
    .src_sel_i     (sel),
    .ext_mclk_en_i (ext_en),
    .mclk_o        (mclk),
    .mclk_en_o     (mclk_en),
    .bclk_en_o     (bclk_en),
    .cfg_err_o     (cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input int act, input int exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (+-1)", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] n, input logic [1:0] s);
    num = x; den = y; bdiv = n; sel = s;
  endtask

  // counts pulses over n cycles, optional external enable every `ext_per` cycles
  task automatic count_win(input int n, input int ext_per,
                           output int m, output int b, output int hi);
    m = 0; b = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk_en) m++;
      if (bclk_en) b++;
      if (mclk) hi++;
      ext_en = (ext_per != 0) && (i % ext_per == 0);
    end
    ext_en = 1'b0;
  endtask

  initial begin
    int m, b, hi;
    int first_m, first_b;
    int x, y;

    // R8: reset state
    repeat (3) @(negedge clk);
    chk("R8 mclk in reset", int'(mclk), 0);
    chk("R8 mclk_en in reset", int'(mclk_en), 0);
    chk("R8 bclk_en in reset", int'(bclk_en), 0);
    rst_n = 1'b1;

    // R1 R4 R5: table of ratios on internal source
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      set_cfg(VEC[v].x, VEC[v].y, VEC[v].n, 2'b00);
      repeat (4) @(negedge clk);
      count_win(WIN, 0, m, b, hi);
      chk_near($sformatf("R1 mclk_en count vec%0d", v), m, int'(VEC[v].exp_m));
      chk_near($sformatf("R4 R5 bclk_en count vec%0d", v), b, int'(VEC[v].exp_b));
      chk($sformatf("R3 no cfg_err vec%0d", v), int'(cfg_err), 0);
    end

    // R2: zero numerator / denominator
    @(negedge clk); set_cfg(8'd0, 8'd9, 8'd0, 2'b00);
    count_win(200, 0, m, b, hi);
    chk("R2 x=0 mclk_en", m, 0);
    chk("R2 x=0 mclk high", hi, 0);
    chk("R2 x=0 cfg_err", int'(cfg_err), 0);
    @(negedge clk); set_cfg(8'd3, 8'd0, 8'd0, 2'b00);
    count_win(200, 0, m, b, hi);
    chk("R2 y=0 mclk_en", m, 0);
    chk("R2 y=0 bclk_en", b, 0);

    // R3: numerator larger than denominator
    @(negedge clk); set_cfg(8'd9, 8'd4, 8'd0, 2'b00);
    count_win(200, 0, m, b, hi);
    chk("R3 cfg_err high", int'(cfg_err), 1);
    chk("R3 mclk_en held", m, 0);
    chk("R3 mclk held low", hi, 0);

    // R5: external source, divide by 3, one enable every 3 cycles
    @(negedge clk); set_cfg(8'd1, 8'd2, 8'd2, 2'b10);
    repeat (4) @(negedge clk);
    count_win(900, 3, m, b, hi);
    chk_near("R5 external source bclk_en", b, 100);

    // R6: reserved selects block the bit clock
    @(negedge clk); set_cfg(8'd1, 8'd2, 8'd0, 2'b01);
    count_win(300, 2, m, b, hi);
    chk("R6 sel=01 bclk_en", b, 0);
    chk_near("R6 sel=01 mclk still runs", m, 75);
    @(negedge clk); set_cfg(8'd1, 8'd2, 8'd0, 2'b11);
    count_win(300, 1, m, b, hi);
    chk("R6 sel=11 bclk_en", b, 0);

    // R7: restart phase after reconfiguration
    x = 2; y = 7;
    @(negedge clk); set_cfg(8'd1, 8'd3, 8'd0, 2'b00);
    repeat (10) @(negedge clk);
    set_cfg(8'(x), 8'(y), 8'd0, 2'b00);
    first_m = 0; first_b = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (mclk_en && first_m == 0) first_m = k;
      if (bclk_en && first_b == 0) first_b = k;
    end
    chk("R7 first mclk_en after change", first_m, (y + x - 1) / x + 1);
    chk("R7 first bclk_en after change", first_b, (y + x - 1) / x + 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule